// File: doc/BRIEF.md
# PAUSE Receive Detector and Transmit Throttle

This block sits beside a full-duplex Ethernet MAC. It watches the receive byte stream, starting at the first destination-address byte, and picks out MAC control frames that ask the link partner to pause. When such a frame ends with a good check indication, it loads the 16-bit pause time from the frame into a down-counter. The counter drops by one on every pause-quantum tick, where one quantum is 512 bit times and the tick is supplied from outside. It also raises an event flag, and that flag drives a maskable interrupt.

On the transmit side, each request carries a tag that marks it as a PAUSE frame. A data-frame request is granted only while the counter is zero. This includes software-built frames with a unique destination address, which simply wait until the count runs out. A PAUSE-tagged request is granted whatever the counter holds. A frame that has already been granted runs to completion and is never revoked. Buffer occupancy on the receive side has no input here, so PAUSE frames are acted on even when every receive buffer is full.

The receive side is a pure monitor. It has no ready signal and never applies back-pressure: every byte presented with `rx_valid` high is consumed in that cycle. The transmit side uses a valid/ready pair. `tx_req_valid` is held by the requester until `tx_grant` is seen high at a clock edge. `tx_grant` may drop while valid is held, for example when a PAUSE frame arrives, and the request then waits.

Top module: `pause_flow_ctl`

## Requirements
- R1: A PAUSE frame is acted on only if `fc_en` and `full_duplex` are both high in the cycle of its last byte; otherwise the counter and the event flag keep their values.
- R2: A frame is recognized only if all of the following hold. Byte offsets count from the first destination-address byte, which is offset 0. Offsets 0..5 equal 01-80-C2-00-00-01 or `station_addr`, with bits 47:40 at offset 0. Offsets 12..13 equal 0x88, 0x08. Offsets 14..15 equal 0x00, 0x01. A mismatch in any of these fields causes the frame to be ignored.
- R3: The pause time is offset 16 (high byte) and offset 17 (low byte). It appears on `pause_quanta` one clock after the last byte (`rx_eof`), provided `rx_good` is high with that byte. A frame whose last byte has `rx_good` low is ignored.
- R4: While `pause_quanta` is nonzero, each cycle with `quantum_tick` high lowers it by exactly one. It never wraps below zero. Without a tick or a load it holds its value.
- R5: A newly recognized frame reloads the counter, even if it is nonzero. A load takes priority over a tick in the same cycle. A pause time of zero ends the pause at once.
- R6: A request with `tx_req_is_pause` low gets `tx_grant` high in the same cycle only if `pause_quanta` is zero and no frame is in flight.
- R7: A request with `tx_req_is_pause` high gets `tx_grant` whenever no frame is in flight, regardless of `pause_quanta`.
- R8: A frame is in flight from the edge where `tx_req_valid` and `tx_grant` are both high until the edge where `tx_done` is high. During that time no request is granted, and a PAUSE frame received meanwhile does not stop the current frame.
- R9: `evt_flag` is set one clock after a recognized frame. A one-cycle `evt_clr` pulse clears it, but a set in the same cycle wins over the clear. `irq` is high exactly when `evt_flag` and `irq_en` are both high.
- R10: A frame that ends before 18 bytes is ignored. Bytes with `rx_valid` high that arrive outside a frame are ignored, where a frame runs from a byte with `rx_sof` to the next byte with `rx_eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_en | input | 1 | Receive flow control enable |
| full_duplex | input | 1 | Link is full duplex |
| station_addr | input | 48 | Own unicast address, first byte in bits 47:40 |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Byte valid (never back-pressured) |
| rx_sof | input | 1 | First byte of frame (destination address byte 0) |
| rx_eof | input | 1 | Last byte of frame |
| rx_good | input | 1 | Frame check passed, meaningful with rx_eof |
| quantum_tick | input | 1 | One pulse per 512 bit times |
| tx_req_valid | input | 1 | Transmit request valid |
| tx_req_is_pause | input | 1 | Request is a PAUSE control frame |
| tx_done | input | 1 | Frame in flight has finished |
| tx_grant | output | 1 | Request accepted (ready) |
| pause_quanta | output | 16 | Remaining pause quanta |
| evt_clr | input | 1 | Clear pulse for the event flag |
| irq_en | input | 1 | Interrupt enable |
| evt_flag | output | 1 | PAUSE frame received event |
| irq | output | 1 | Interrupt request |

## Verification
If the byte-offset tracking or a field match goes wrong, the next PAUSE frame either fails to show its pause time on `pause_quanta` one clock after the last byte, or a malformed frame loads a value. Either fault is visible within a single frame. A counter fault shows up on the first quantum tick as a step other than one, or as a wrap below zero. An error in the in-flight tracking shows up in the same cycle as the next request probe: `tx_grant` either appears while a frame is still in progress or is missing after `tx_done`. A fault in the event logic is visible one clock after detection or after a clear pulse.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int unsigned PT_W      = 16;
  localparam int unsigned MAC_BYTES = 6;
  localparam logic [47:0] FC_MCAST  = 48'h0180C2000001;
  localparam logic [15:0] CTL_ETYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPC = 16'h0001;
  localparam int unsigned OFS_TYPE  = 12;
  localparam int unsigned OFS_OPC   = 14;
  localparam int unsigned OFS_PARAM = 16;
  localparam int unsigned MIN_BYTES = 18;

  typedef struct packed {
    logic mc_ok;
    logic uc_ok;
    logic type_ok;
    logic opc_ok;
  } pfc_match_t;
endpackage

// File: rtl/pfc_rx_parser.sv
module pfc_rx_parser
  import pfc_pkg::*;
#(
  parameter int unsigned IDX_W = $clog2(MIN_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fc_en,
  input  logic            full_duplex,
  input  logic [47:0]     station_addr,
  input  logic [7:0]      rx_data,
  input  logic            rx_valid,
  input  logic            rx_sof,
  input  logic            rx_eof,
  input  logic            rx_good,
  output logic            pause_load,
  output logic [PT_W-1:0] pause_val
);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(MIN_BYTES);

  logic [IDX_W-1:0] idx_q, base_idx, nxt_idx;
  logic             in_frame_q, take;
  pfc_match_t       match_q, base_match, nxt_match;
  logic [PT_W-1:0]  param_q, base_param, nxt_param;
  logic [MAC_BYTES-1:0] mc_hit, uc_hit;

  assign take       = rx_valid && (rx_sof || in_frame_q);
  assign base_idx   = rx_sof ? '0 : idx_q;
  assign base_match = rx_sof ? '1 : match_q;
  assign base_param = rx_sof ? '0 : param_q;

  // one comparator per destination-address byte position
  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_da
    localparam logic [7:0] MC_BYTE = FC_MCAST[47-8*g -: 8];
    assign mc_hit[g] = (base_idx != IDX_W'(g)) || (rx_data == MC_BYTE);
    assign uc_hit[g] = (base_idx != IDX_W'(g)) || (rx_data == station_addr[47-8*g -: 8]);
  end

  always_comb begin
    nxt_match        = base_match;
    nxt_param        = base_param;
    nxt_match.mc_ok  = base_match.mc_ok & (&mc_hit);
    nxt_match.uc_ok  = base_match.uc_ok & (&uc_hit);
    if (base_idx == IDX_W'(OFS_TYPE))
      nxt_match.type_ok = base_match.type_ok & (rx_data == CTL_ETYPE[15:8]);
    if (base_idx == IDX_W'(OFS_TYPE + 1))
      nxt_match.type_ok = base_match.type_ok & (rx_data == CTL_ETYPE[7:0]);
    if (base_idx == IDX_W'(OFS_OPC))
      nxt_match.opc_ok = base_match.opc_ok & (rx_data == PAUSE_OPC[15:8]);
    if (base_idx == IDX_W'(OFS_OPC + 1))
      nxt_match.opc_ok = base_match.opc_ok & (rx_data == PAUSE_OPC[7:0]);
    if (base_idx == IDX_W'(OFS_PARAM))
      nxt_param[15:8] = rx_data;
    if (base_idx == IDX_W'(OFS_PARAM + 1))
      nxt_param[7:0] = rx_data;
    nxt_idx = (base_idx < IDX_END) ? base_idx + 1'b1 : base_idx;
  end

  assign pause_load = take && rx_eof && rx_good && fc_en && full_duplex &&
                      (nxt_idx == IDX_END) &&
                      (nxt_match.mc_ok || nxt_match.uc_ok) &&
                      nxt_match.type_ok && nxt_match.opc_ok;
  assign pause_val  = nxt_param;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q      <= '0;
      in_frame_q <= 1'b0;
      match_q    <= '0;
      param_q    <= '0;
    end else if (take) begin
      idx_q      <= nxt_idx;
      match_q    <= nxt_match;
      param_q    <= nxt_param;
      in_frame_q <= !rx_eof;
    end
  end
endmodule

// File: rtl/pfc_quanta_timer.sv
module pfc_quanta_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             paused
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign count  = cnt_q;
  assign paused = (cnt_q != '0);
endmodule

// File: rtl/pfc_tx_gate.sv
module pfc_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic paused,
  input  logic req_valid,
  input  logic req_is_pause,
  input  logic tx_done,
  output logic grant,
  output logic busy
);
  logic busy_q;

  assign grant = req_valid && !busy_q && (req_is_pause || !paused);
  assign busy  = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                busy_q <= 1'b0;
    else if (grant)            busy_q <= 1'b1;
    else if (busy_q && tx_done) busy_q <= 1'b0;
  end
endmodule

// File: rtl/pause_flow_ctl.sv
module pause_flow_ctl
  import pfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fc_en,
  input  logic            full_duplex,
  input  logic [47:0]     station_addr,
  input  logic [7:0]      rx_data,
  input  logic            rx_valid,
  input  logic            rx_sof,
  input  logic            rx_eof,
  input  logic            rx_good,
  input  logic            quantum_tick,
  input  logic            tx_req_valid,
  input  logic            tx_req_is_pause,
  input  logic            tx_done,
  output logic            tx_grant,
  output logic [PT_W-1:0] pause_quanta,
  input  logic            evt_clr,
  input  logic            irq_en,
  output logic            evt_flag,
  output logic            irq
);
  logic            pause_load;
  logic [PT_W-1:0] pause_val;
  logic            paused;
  logic            tx_busy;
  logic            flag_q;

  pfc_rx_parser u_parse (
    .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .full_duplex(full_duplex),
    .station_addr(station_addr), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_good(rx_good),
    .pause_load(pause_load), .pause_val(pause_val)
  );

  pfc_quanta_timer #(.CNT_W(PT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(pause_load), .load_val(pause_val),
    .tick(quantum_tick), .count(pause_quanta), .paused(paused)
  );

  pfc_tx_gate u_gate (
    .clk(clk), .rst_n(rst_n), .paused(paused), .req_valid(tx_req_valid),
    .req_is_pause(tx_req_is_pause), .tx_done(tx_done),
    .grant(tx_grant), .busy(tx_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (pause_load) flag_q <= 1'b1;
    else if (evt_clr)    flag_q <= 1'b0;
  end

  assign evt_flag = flag_q;
  assign irq      = flag_q && irq_en;
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        fc_en,
  input logic        full_duplex,
  input logic        quantum_tick,
  input logic        tx_req_valid,
  input logic        tx_req_is_pause,
  input logic        tx_grant,
  input logic        tx_busy,
  input logic        pause_load,
  input logic [15:0] pause_val,
  input logic [15:0] pause_quanta,
  input logic        evt_flag,
  input logic        irq_en,
  input logic        irq
);
  assert_gate_enables_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(fc_en && full_duplex) |-> !pause_load);

  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_load && quantum_tick && pause_quanta != 16'd0) |=>
      pause_quanta == $past(pause_quanta) - 16'd1);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_load && (!quantum_tick || pause_quanta == 16'd0)) |=> $stable(pause_quanta));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pause_load |=> pause_quanta == $past(pause_val));

  assert_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_quanta != 16'd0 && !tx_req_is_pause) |-> !tx_grant);

  assert_pause_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_valid && tx_req_is_pause && !tx_busy) |-> tx_grant);

  assert_inflight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !tx_grant);

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pause_load |=> evt_flag);

  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind pause_flow_ctl pfc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .full_duplex(full_duplex),
  .quantum_tick(quantum_tick), .tx_req_valid(tx_req_valid),
  .tx_req_is_pause(tx_req_is_pause), .tx_grant(tx_grant), .tx_busy(tx_busy),
  .pause_load(pause_load), .pause_val(pause_val), .pause_quanta(pause_quanta),
  .evt_flag(evt_flag), .irq_en(irq_en), .irq(irq)
);

// File: tb/sim_pause_flow_ctl.sv
`timescale 1ns/1ps
module sim_pause_flow_ctl;
  localparam logic [47:0] MC   = 48'h0180C2000001;
  localparam logic [47:0] OWN  = 48'h02AB34CD56EF;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        fc_en = 1'b1, full_duplex = 1'b1;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_good = 0;
  logic        quantum_tick = 0, tx_req_valid = 0, tx_req_is_pause = 0, tx_done = 0;
  logic        evt_clr = 0, irq_en = 0;
  logic        tx_grant, evt_flag, irq;
  logic [15:0] pause_quanta;
  int checks = 0, failures = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  pause_flow_ctl u0 (
    .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .full_duplex(full_duplex),
    .station_addr(OWN), .rx_data(rx_data), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_good(rx_good), .quantum_tick(quantum_tick),
    .tx_req_valid(tx_req_valid), .tx_req_is_pause(tx_req_is_pause),
    .tx_done(tx_done), .tx_grant(tx_grant), .pause_quanta(pause_quanta),
    .evt_clr(evt_clr), .irq_en(irq_en), .evt_flag(evt_flag), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(int i, logic [47:0] da, logic [15:0] ty,
                                       logic [15:0] op, logic [15:0] pv);
    if (i < 6)       return da[47-8*i -: 8];
    else if (i < 12) return 8'(8'h10 + i);
    else if (i == 12) return ty[15:8];
    else if (i == 13) return ty[7:0];
    else if (i == 14) return op[15:8];
    else if (i == 15) return op[7:0];
    else if (i == 16) return pv[15:8];
    else if (i == 17) return pv[7:0];
    return 8'h00;
  endfunction

  // drive frame; on return the last byte has been clocked and one more edge has not
  task automatic send(logic [47:0] da, logic [15:0] ty, logic [15:0] op,
                      logic [15:0] pv, int len, logic good);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fbyte(i, da, ty, op, pv);
      rx_sof = (i == 0); rx_eof = (i == len - 1); rx_good = good && (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0;
  endtask

  task automatic pause_frm(logic [15:0] pv);
    send(MC, 16'h8808, 16'h0001, pv, 64, 1'b1);
  endtask

  task automatic tick();
    @(negedge clk); quantum_tick = 1;
    @(negedge clk); quantum_tick = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); evt_clr = 1;
    @(negedge clk); evt_clr = 0;
  endtask

  // present a request without letting it be accepted
  task automatic probe(logic is_pause, output logic g);
    @(negedge clk);
    tx_req_valid = 1; tx_req_is_pause = is_pause;
    #1 g = tx_grant;
    #1 tx_req_valid = 0; tx_req_is_pause = 0;
  endtask

  task automatic t_reset();
    logic g;
    chk("R4 reset quanta", pause_quanta, 0);
    chk("R9 reset flag", evt_flag, 0);
    chk("R9 reset irq", irq, 0);
    probe(0, g); chk("R6 idle data grant", g, 1);
  endtask

  task automatic t_basic();
    logic g;
    irq_en = 1;
    pause_frm(16'd5);
    chk("R3 quanta loaded", pause_quanta, 5);
    chk("R2 multicast DA accepted", pause_quanta != 0, 1);
    chk("R9 flag set", evt_flag, 1);
    chk("R9 irq", irq, 1);
    irq_en = 0; #1 chk("R9 irq masked", irq, 0);
    probe(0, g); chk("R6 data held while paused", g, 0);
    probe(1, g); chk("R7 pause frame passes", g, 1);
  endtask

  task automatic t_ticks();
    logic g;
    tick(); chk("R4 first step", pause_quanta, 4);
    for (int i = 0; i < 4; i++) tick();
    chk("R4 reaches zero", pause_quanta, 0);
    tick(); chk("R4 no wrap", pause_quanta, 0);
    repeat (3) @(negedge clk); chk("R4 hold", pause_quanta, 0);
    probe(0, g); chk("R6 data released", g, 1);
  endtask

  task automatic t_unicast_reload();
    clear_flag(); chk("R9 flag cleared", evt_flag, 0);
    send(OWN, 16'h8808, 16'h0001, 16'd300, 64, 1'b1);
    chk("R2 own DA accepted", pause_quanta, 300);
    pause_frm(16'd7); chk("R5 reload while nonzero", pause_quanta, 7);
    // load with a tick in the same cycle: tick held across the final edge
    fork
      pause_frm(16'd20);
      begin repeat (64) @(negedge clk); quantum_tick = 1; @(negedge clk); quantum_tick = 0; end
    join
    chk("R5 load beats tick", pause_quanta, 20);
    pause_frm(16'd0); chk("R5 zero cancels", pause_quanta, 0);
  endtask

  task automatic t_rejects();
    clear_flag();
    send(MC, 16'h0800, 16'h0001, 16'd9, 64, 1'b1); chk("R2 wrong type", pause_quanta, 0);
    send(MC, 16'h8808, 16'h0002, 16'd9, 64, 1'b1); chk("R2 wrong opcode", pause_quanta, 0);
    send(48'h0180C2000002, 16'h8808, 16'h0001, 16'd9, 64, 1'b1); chk("R2 wrong DA", pause_quanta, 0);
    send(MC, 16'h8808, 16'h0001, 16'd9, 64, 1'b0); chk("R3 bad frame ignored", pause_quanta, 0);
    send(MC, 16'h8808, 16'h0001, 16'd9, 16, 1'b1); chk("R10 short frame", pause_quanta, 0);
    chk("R2 no flag on rejects", evt_flag, 0);
  endtask

  task automatic t_outside();
    // stray bytes with no sof, then a frame body ending in eof without sof
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fbyte(i, MC, 16'h8808, 16'h0001, 16'd9);
      rx_eof = (i == 63); rx_good = (i == 63);
    end
    @(negedge clk); rx_valid = 0; rx_eof = 0; rx_good = 0;
    chk("R10 bytes outside frame", pause_quanta, 0);
  endtask

  task automatic t_enables();
    fc_en = 0; pause_frm(16'd9); chk("R1 disabled", pause_quanta, 0);
    fc_en = 1; full_duplex = 0; pause_frm(16'd9); chk("R1 half duplex", pause_quanta, 0);
    chk("R1 no flag", evt_flag, 0);
    full_duplex = 1;
  endtask

  task automatic t_inflight();
    logic g;
    @(negedge clk); tx_req_valid = 1; tx_req_is_pause = 0;
    #1 chk("R6 data grant at zero", tx_grant, 1);
    @(negedge clk); tx_req_valid = 0;
    probe(1, g); chk("R8 busy blocks pause req", g, 0);
    probe(0, g); chk("R8 busy blocks data req", g, 0);
    // set flag by a pause while a frame is in flight, clear in same cycle
    fork
      pause_frm(16'd9);
      begin repeat (64) @(negedge clk); evt_clr = 1; @(negedge clk); evt_clr = 0; end
    join
    chk("R9 set wins over clear", evt_flag, 1);
    chk("R8 pause loaded during flight", pause_quanta, 9);
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    probe(0, g); chk("R6 data held after done", g, 0);
    probe(1, g); chk("R8 free after done, R7 pause grant", g, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ticks();
    t_unicast_reload();
    t_rejects();
    t_outside();
    t_enables();
    t_inflight();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule